// File: doc/BRIEF.md
# Operand Transition Weighted Detector

This block sits beside one row of processing elements and estimates, from the operand stream fed to that row, how long the next compute cycle needs. Each accepted operand word is held in a one-stage buffer and XORed against the word accepted before it. Every bit that toggled adds its own programmable weight to a running score. The score saturates, its upper bits index a small programmable table, and the table entry is the clock-period code for the next cycle. A larger code asks for a longer period.

Two dataflows are supported. In SIMD mode one score serves the whole row and the output follows only the latest transition. In systolic mode, where operands keep moving across the row for several cycles, the block keeps the codes of recent words and reports the largest code over a window of eight results. Weights and table entries are loaded through a simple address/data/write-enable port. Reset fills every unfilled history slot, and the whole table, with the slowest code.

Top module: `toggle_slack_predictor`

## Requirements
- R1: While reset is asserted, and after it until the first configuration write or operand, `period_code` is all ones (15, the slowest setting) in both modes.
- R2: A word accepted on a rising edge with `in_valid` high changes `period_code` from that edge on. Before that edge the output still shows the previous result.
- R3: The first valid word after reset is scored as having no toggling bits (weighted score 0), whatever its value.
- R4: The score is the sum of the weights of the bit positions that differ between the buffered word and the previous accepted word. Its upper four bits (bits 7 to 4 of the 8-bit score) index the table.
- R5: The score saturates at 255, so an overflowing sum selects table entry 15.
- R6: With `in_valid` low, `cfg_we` low and the mode held, `period_code` does not change.
- R7: With `mode_systolic` at 0 (SIMD), `period_code` is the table entry for the latest transition only.
- R8: With `mode_systolic` at 1, `period_code` is the largest code among the latest result and the results of the seven valid words before it. History slots not yet filled since reset count as 15. A mode change takes effect in the same cycle.
- R9: A write with `cfg_addr` 0 to 63 sets the 4-bit weight of operand bit `cfg_addr`. Addresses 64 to 79 set table entry `cfg_addr`-64, and that entry is seen on the output at once. Addresses 80 and above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand word qualifier |
| in_data | input | 64 | Operand word for the row |
| mode_systolic | input | 1 | 0 selects SIMD, 1 selects systolic windowing |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 7 | Configuration address: weights, then table |
| cfg_wdata | input | 4 | Configuration write data |
| period_code | output | 4 | Target clock-period code, larger is slower |

## Verification
The bench starts with a nonzero first word. A design that compared it against the cleared buffer would report a large score in place of zero. A burst toggling seven lanes drives the raw sum past 255: without saturation the sum would wrap to a low index and ask for a fast clock. In systolic mode a slow result must stay on the output for exactly seven more words and leave on the eighth. A window that is one slot short or one slot long would release the result a word early or hold it a word late. An out-of-range write to address 80 must leave table entry 0 alone, which catches an address decode that aliases it.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    typedef enum logic {
        FLOW_SIMD     = 1'b0,
        FLOW_SYSTOLIC = 1'b1
    } flow_mode_e;

    function automatic logic [3:0] code_max4(input logic [3:0] a, input logic [3:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tsp_cfg_store.sv
module tsp_cfg_store #(
    parameter int DATA_W    = 64,
    parameter int WT_W      = 4,
    parameter int CODE_W    = 4,
    parameter int LUT_DEPTH = 16,
    parameter int CFG_AW    = 7,
    parameter int CFG_DW    = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [CFG_AW-1:0]                   addr,
    input  logic [CFG_DW-1:0]                   wdata,
    output logic [DATA_W-1:0][WT_W-1:0]         weights,
    output logic [LUT_DEPTH-1:0][CODE_W-1:0]    table_q
);

    localparam int WI_W  = $clog2(DATA_W);
    localparam int IDX_W = $clog2(LUT_DEPTH);

    typedef struct packed {
        logic [DATA_W-1:0][WT_W-1:0]      wt;
        logic [LUT_DEPTH-1:0][CODE_W-1:0] lut;
    } cfg_state_t;

    cfg_state_t state_d, state_q;
    logic [CFG_AW-1:0] lut_off;

    always_comb begin
        state_d = state_q;
        lut_off = addr - CFG_AW'(DATA_W);
        if (we) begin
            if (int'(addr) < DATA_W) begin
                state_d.wt[addr[WI_W-1:0]] = wdata[WT_W-1:0];
            end else if (int'(addr) < DATA_W + LUT_DEPTH) begin
                state_d.lut[lut_off[IDX_W-1:0]] = wdata[CODE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.wt  <= '0;
            state_q.lut <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign weights = state_q.wt;
    assign table_q = state_q.lut;

endmodule

// File: rtl/tsp_toggle_score.sv
module tsp_toggle_score #(
    parameter int DATA_W = 64,
    parameter int WT_W   = 4,
    parameter int SUM_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [DATA_W-1:0]           in_data,
    input  logic [DATA_W-1:0][WT_W-1:0] weights,
    output logic [SUM_W-1:0]            wsum,
    output logic                        primed
);

    localparam int FULL_W  = $clog2(DATA_W * ((1 << WT_W) - 1) + 1);
    localparam int ACC_W   = (FULL_W > SUM_W) ? FULL_W : SUM_W;
    localparam int SUM_MAX = (1 << SUM_W) - 1;

    typedef struct packed {
        logic [DATA_W-1:0] held;
        logic [DATA_W-1:0] prior;
        logic              primed;
    } score_state_t;

    score_state_t state_d, state_q;

    logic [DATA_W-1:0]           toggled;
    logic [DATA_W-1:0][WT_W-1:0] gated;
    logic [ACC_W-1:0]            acc;

    always_comb begin
        state_d = state_q;
        if (in_valid) begin
            state_d.held   = in_data;
            state_d.prior  = state_q.primed ? state_q.held : in_data;
            state_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign toggled = state_q.held ^ state_q.prior;

    for (genvar g = 0; g < DATA_W; g++) begin : g_gate
        assign gated[g] = toggled[g] ? weights[g] : '0;
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < DATA_W; i++) begin
            acc = acc + ACC_W'(gated[i]);
        end
    end

    assign wsum   = (acc > ACC_W'(SUM_MAX)) ? '1 : acc[SUM_W-1:0];
    assign primed = state_q.primed;

endmodule

// File: rtl/tsp_window.sv
module tsp_window #(
    parameter int CODE_W = 4,
    parameter int WINDOW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              systolic,
    input  logic [CODE_W-1:0] cur_code,
    output logic [CODE_W-1:0] period_code
);

    localparam int HIST_N = WINDOW - 1;

    typedef struct packed {
        logic [HIST_N-1:0][CODE_W-1:0] hist;
    } win_state_t;

    win_state_t state_d, state_q;
    logic [HIST_N:0][CODE_W-1:0] running;

    always_comb begin
        state_d = state_q;
        if (push) begin
            state_d.hist[0] = cur_code;
            for (int i = 1; i < HIST_N; i++) begin
                state_d.hist[i] = state_q.hist[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign running[0] = cur_code;
    for (genvar g = 0; g < HIST_N; g++) begin : g_max
        assign running[g+1] = (running[g] > state_q.hist[g]) ? running[g] : state_q.hist[g];
    end

    assign period_code = systolic ? running[HIST_N] : cur_code;

endmodule

// File: rtl/toggle_slack_predictor.sv
module toggle_slack_predictor #(
    parameter int LANES     = 8,
    parameter int LANE_W    = 8,
    parameter int WT_W      = 4,
    parameter int SUM_W     = 8,
    parameter int CODE_W    = 4,
    parameter int LUT_DEPTH = 16,
    parameter int WINDOW    = 8,
    parameter int DATA_W    = LANES * LANE_W,
    parameter int CFG_AW    = $clog2(DATA_W + LUT_DEPTH),
    parameter int CFG_DW    = (WT_W > CODE_W) ? WT_W : CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              mode_systolic,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CODE_W-1:0] period_code
);

    import tsp_pkg::*;

    localparam int IDX_W = $clog2(LUT_DEPTH);

    logic [DATA_W-1:0][WT_W-1:0]      weights;
    logic [LUT_DEPTH-1:0][CODE_W-1:0] table_q;
    logic [SUM_W-1:0]                 wsum;
    logic                             primed;
    logic [IDX_W-1:0]                 lut_idx;
    logic [CODE_W-1:0]                cur_code;
    flow_mode_e                       flow;

    assign flow = flow_mode_e'(mode_systolic);

    tsp_cfg_store #(
        .DATA_W(DATA_W), .WT_W(WT_W), .CODE_W(CODE_W),
        .LUT_DEPTH(LUT_DEPTH), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .weights(weights), .table_q(table_q)
    );

    tsp_toggle_score #(
        .DATA_W(DATA_W), .WT_W(WT_W), .SUM_W(SUM_W)
    ) u_score (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .weights(weights), .wsum(wsum), .primed(primed)
    );

    assign lut_idx  = wsum[SUM_W-1 -: IDX_W];
    assign cur_code = table_q[lut_idx];

    tsp_window #(
        .CODE_W(CODE_W), .WINDOW(WINDOW)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .push(in_valid && primed),
        .systolic(flow == FLOW_SYSTOLIC), .cur_code(cur_code),
        .period_code(period_code)
    );

endmodule

// File: rtl/tsp_checker.sv
module tsp_checker #(
    parameter int CODE_W     = 4,
    parameter int SUM_W      = 8,
    parameter int CFG_AW     = 7,
    parameter int ADDR_LIMIT = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mode_systolic,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [CODE_W-1:0] period_code,
    input logic [CODE_W-1:0] cur_code,
    input logic [SUM_W-1:0]  wsum,
    input logic              primed
);

    assert_reset_slowest_R1: assert property (@(posedge clk)
        !rst_n |=> (period_code == '1));

    assert_first_word_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !primed) |=> (wsum == '0));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !cfg_we) |=> (!$stable(mode_systolic) || $stable(period_code)));

    assert_window_dominates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_systolic |-> (period_code >= cur_code));

    assert_range_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !in_valid && (int'(cfg_addr) >= ADDR_LIMIT))
        |=> (!$stable(mode_systolic) || $stable(period_code)));

endmodule

bind toggle_slack_predictor tsp_checker #(
    .CODE_W(CODE_W), .SUM_W(SUM_W), .CFG_AW(CFG_AW), .ADDR_LIMIT(DATA_W + LUT_DEPTH)
) u_tsp_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_systolic(mode_systolic),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .period_code(period_code),
    .cur_code(cur_code), .wsum(wsum), .primed(primed)
);

// File: tb/test_toggle_slack_predictor.sv
`timescale 1ns/1ps
module test_toggle_slack_predictor;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_data;
    logic        mode_systolic;
    logic        cfg_we;
    logic [6:0]  cfg_addr;
    logic [3:0]  cfg_wdata;
    logic [3:0]  period_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    toggle_slack_predictor i_toggle_slack_predictor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .mode_systolic(mode_systolic), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .period_code(period_code)
    );

    initial begin
        clk = 1'b0;
        forever #2 clk = ~clk;
    end

    typedef struct packed {
        logic [63:0] data;
        logic        valid;
        logic        sys;
        logic [3:0]  exp;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 20;
    // Weights: bit i has weight (i/8)+1. Table entry j holds code j.
    localparam vec_t VECS [NV] = '{
        '{64'h0123456789ABCDEF, 1'b1, 1'b0, 4'd0,  "R3"},
        '{64'h0000000000000000, 1'b1, 1'b0, 4'd7,  "R4"},
        '{64'h00000000000000FF, 1'b1, 1'b0, 4'd0,  "R4"},
        '{64'hFF000000000000FF, 1'b1, 1'b0, 4'd4,  "R7"},
        '{64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b0, 4'd4,  "R6"},
        '{64'hFF000000000000FF, 1'b1, 1'b0, 4'd0,  "R7"},
        '{64'h00000000000000FF, 1'b1, 1'b0, 4'd4,  "R4"},
        '{64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 4'd15, "R5"},
        '{64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 4'd0,  "R7"},
        '{64'hFFFFFFFFFFFFFF00, 1'b1, 1'b0, 4'd0,  "R4"},
        '{64'hFFFFFFFFFFFFFF00, 1'b0, 1'b1, 4'd15, "R8"},
        '{64'hFFFFFFFFFFFFFF00, 1'b1, 1'b1, 4'd15, "R8"},
        '{64'hFFFFFFFFFFFFFF00, 1'b1, 1'b1, 4'd15, "R8"},
        '{64'hFFFFFFFFFFFFFF00, 1'b1, 1'b1, 4'd15, "R8"},
        '{64'hFFFFFFFFFFFFFF00, 1'b1, 1'b1, 4'd15, "R8"},
        '{64'hFFFFFFFFFFFFFF00, 1'b1, 1'b1, 4'd15, "R8"},
        '{64'hFFFFFFFFFFFFFF00, 1'b1, 1'b1, 4'd0,  "R8"},
        '{64'h00FFFFFFFFFFFF00, 1'b1, 1'b1, 4'd4,  "R8"},
        '{64'h00FFFFFFFFFFFF00, 1'b1, 1'b1, 4'd4,  "R8"},
        '{64'h00FFFFFFFFFFFF00, 1'b0, 1'b0, 4'd0,  "R7"}
    };

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: period_code %0d, expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input int addr, input int val);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 7'(addr);
        cfg_wdata = 4'(val);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: period_code %0d, expected run to complete", period_code);
        finish_run();
    end

    initial begin
        logic [3:0] prev_exp;
        logic       prev_sys;
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; mode_systolic = 1'b0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(period_code, 4'd15, "R1 reset SIMD");
        mode_systolic = 1'b1;
        #1 check(period_code, 4'd15, "R1 reset systolic");
        mode_systolic = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(period_code, 4'd15, "R1 after release");

        for (int i = 0; i < 64; i++) write_cfg(i, (i / 8) + 1);
        for (int j = 0; j < 16; j++) write_cfg(64 + j, j);
        check(period_code, 4'd0, "R9 table programmed");

        prev_exp = 4'd0;
        prev_sys = 1'b0;
        for (int k = 0; k < NV; k++) begin
            in_data       = VECS[k].data;
            in_valid      = VECS[k].valid;
            mode_systolic = VECS[k].sys;
            #1;
            if (VECS[k].sys == prev_sys) check(period_code, prev_exp, "R2 before edge");
            @(posedge clk);
            @(negedge clk);
            check(period_code, VECS[k].exp, $sformatf("%s vector %0d", VECS[k].tag, k));
            prev_exp = VECS[k].exp;
            prev_sys = VECS[k].sys;
        end
        in_valid = 1'b0;

        // R9: table entry 0 is live, out-of-range addresses leave it alone
        write_cfg(64, 9);
        check(period_code, 4'd9, "R9 entry write");
        write_cfg(80, 3);
        check(period_code, 4'd9, "R9 address 80 ignored");
        write_cfg(127, 3);
        check(period_code, 4'd9, "R9 address 127 ignored");

        // R1: reset mid-run restores the slowest code in both modes
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(period_code, 4'd15, "R1 mid-run SIMD");
        mode_systolic = 1'b1;
        #1 check(period_code, 4'd15, "R1 mid-run systolic");
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule